// File: doc/BRIEF.md
# Absolute-to-Quadrature Encoder Emulator

This block turns a stream of sampled absolute shaft angles into the A, B and index signals of an incremental encoder, so that a servo drive that expects incremental feedback can be fed from an absolute encoder that is read at intervals. Each time a new sample is presented, the block compares it with the angle it holds as its reference. A change of exactly one code moves the two-bit quadrature state one position in the matching direction. A direction-invert input swaps which rotation sense counts upward.

The emulation is only exact if the shaft moves by no more than one code between samples. A larger change means that codes were missed because the sample rate was too low for the shaft speed. In that case the block raises a sticky conversion error and does not step. It then takes the new angle as its reference. The error stays set until a clear command arrives. When automatic clearing is enabled, the error also clears on the next accepted sample whose angle is zero.

Top module: `qenc_emulator`

## Requirements
- R1: After reset, quadA, quadB, index and convErr are all 0 and no reference angle is held.
- R2: The first sample after reset only loads the reference: the quadrature state does not move and convErr stays 0.
- R3: A sample exactly one above the reference (modulo 2^15) moves {quadA,quadB} one step along 00→01→11→10→00. A sample one below moves it one step the other way. The new state appears in the cycle after the sample strobe, and only one of A and B changes.
- R4: A sample equal to the reference changes no output.
- R5: With dirInvert = 1, the step directions of R3 are swapped: an increase by one steps along 00→10→11→01→00.
- R6: A change from 32767 to 0, or from 0 to 32767, is a single step and sets no error.
- R7: A sample differing from the reference by more than one code (modulo 2^15) sets convErr in the cycle after the strobe. The quadrature state stays where it was, and the sample becomes the new reference.
- R8: Once convErr is set, it stays set while no clear condition occurs, whatever steps follow.
- R9: clearErr = 1 clears convErr in the next cycle, in either clearing mode. A jump in the same cycle takes priority, and convErr is then set.
- R10: With autoClear = 1, an accepted sample (not a jump) whose angle is 0 clears convErr. With autoClear = 0, passing through zero leaves convErr set.
- R11: index is 1 exactly while a reference is held and that reference equals 0.
- R12: While sampleValid = 0, angleIn is ignored and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe: angleIn holds a new sample |
| angleIn | input | 15 | Absolute angle sample |
| dirInvert | input | 1 | 1 swaps the counting sense |
| autoClear | input | 1 | 1 enables clearing of convErr at angle zero |
| clearErr | input | 1 | Clear command for convErr |
| quadA | output | 1 | Emulated A channel |
| quadB | output | 1 | Emulated B channel |
| index | output | 1 | Emulated index, high while the reference is zero |
| convErr | output | 1 | Sticky missing-code error |

## Verification
The hardest case to reach from the ports is the wrap between 32767 and 0, together with the automatic clear at zero. Both occur only after the reference has travelled across the whole angle range. The bench therefore drives a complete single-step revolution of 32768 samples, checking every quadrature state and the index along the way. To reach the zero crossing with the error already set, it plants the reference just below the wrap with a deliberate jump, then walks it through zero in both clearing modes. It also forces a jump and a clear command into the same cycle, to check which one wins.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // Strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic loadRef;  // take angleIn as new reference
    logic stepUp;   // advance quadrature state
    logic stepDn;   // retreat quadrature state
    logic setErr;   // missing-code detected
    logic clrErr;   // clear condition present
  } qencStrobe_t;
endpackage

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int ANGLE_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic [ANGLE_W-1:0] angleIn,
  input  logic [ANGLE_W-1:0] refAngle,
  input  logic               refValid,
  input  logic               dirInvert,
  input  logic               autoClear,
  input  logic               clearErr,
  output qencStrobe_t        strb
);
  localparam logic [ANGLE_W-1:0] ONE    = ANGLE_W'(1);
  localparam logic [ANGLE_W-1:0] MINUS1 = {ANGLE_W{1'b1}};

  logic [ANGLE_W-1:0] delta;
  logic isSame, isUp, isDn, isJump, atZero, fwd;

  always_comb begin
    delta  = angleIn - refAngle;  // modulo 2^ANGLE_W, wrap is one step
    isSame = (delta == '0);
    isUp   = (delta == ONE);
    isDn   = (delta == MINUS1);
    isJump = refValid && !(isSame || isUp || isDn);
    atZero = (angleIn == '0);
    fwd    = isUp ^ dirInvert;
  end

  always_comb begin
    strb = '0;
    if (sampleValid) begin
      if (!refValid) begin
        strb.loadRef = 1'b1;
      end else if (isUp || isDn) begin
        strb.loadRef = 1'b1;
        strb.stepUp  = fwd;
        strb.stepDn  = !fwd;
      end else if (isJump) begin
        strb.loadRef = 1'b1;
        strb.setErr  = 1'b1;
      end
    end
    strb.clrErr = clearErr ||
                  (sampleValid && autoClear && refValid && !isJump && atZero);
  end

  // R3: never more than one action on the quadrature state per cycle
  p_single_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.stepUp, strb.stepDn, strb.setErr}));

  // R12: without a sample strobe the reference is never touched
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |-> !(strb.loadRef || strb.stepUp || strb.stepDn || strb.setErr));
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int ANGLE_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  qencStrobe_t        strb,
  input  logic [ANGLE_W-1:0] angleIn,
  output logic [ANGLE_W-1:0] refAngle,
  output logic               refValid,
  output logic               quadA,
  output logic               quadB,
  output logic               index,
  output logic               convErr
);
  logic [1:0] quadState, quadNext;   // {A,B}
  logic [ANGLE_W-1:0] refNext;
  logic refValidNext;

  always_comb begin
    quadNext = quadState;
    if (strb.stepUp) begin
      unique case (quadState)
        2'b00: quadNext = 2'b01;
        2'b01: quadNext = 2'b11;
        2'b11: quadNext = 2'b10;
        default: quadNext = 2'b00;
      endcase
    end else if (strb.stepDn) begin
      unique case (quadState)
        2'b00: quadNext = 2'b10;
        2'b10: quadNext = 2'b11;
        2'b11: quadNext = 2'b01;
        default: quadNext = 2'b00;
      endcase
    end
    refNext      = strb.loadRef ? angleIn : refAngle;
    refValidNext = refValid || strb.loadRef;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quadState <= 2'b00;
      refAngle  <= '0;
      refValid  <= 1'b0;
      index     <= 1'b0;
      convErr   <= 1'b0;
    end else begin
      quadState <= quadNext;
      refAngle  <= refNext;
      refValid  <= refValidNext;
      index     <= refValidNext && (refNext == '0);
      if (strb.setErr)      convErr <= 1'b1;
      else if (strb.clrErr) convErr <= 1'b0;
    end
  end

  assign quadA = quadState[1];
  assign quadB = quadState[0];

  // R3: at most one of A and B changes per cycle
  p_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({quadA, quadB} ^ $past({quadA, quadB})) <= 1);

  // R7: a jump sets the error and freezes the quadrature state
  p_jump_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setErr |=> convErr);
  p_jump_nostep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setErr |=> $stable({quadA, quadB}));

  // R8: error holds without a clear condition
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (convErr && !strb.clrErr) |=> convErr);
endmodule

// File: rtl/qenc_emulator.sv
module qenc_emulator
  import qenc_pkg::*;
#(
  parameter int ANGLE_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic [ANGLE_W-1:0] angleIn,
  input  logic               dirInvert,
  input  logic               autoClear,
  input  logic               clearErr,
  output logic               quadA,
  output logic               quadB,
  output logic               index,
  output logic               convErr
);
  qencStrobe_t        strb;
  logic [ANGLE_W-1:0] refAngle;
  logic               refValid;

  qenc_ctrl #(.ANGLE_W(ANGLE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .angleIn(angleIn),
    .refAngle(refAngle), .refValid(refValid), .dirInvert(dirInvert),
    .autoClear(autoClear), .clearErr(clearErr), .strb(strb));

  qenc_datapath #(.ANGLE_W(ANGLE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .angleIn(angleIn),
    .refAngle(refAngle), .refValid(refValid), .quadA(quadA), .quadB(quadB),
    .index(index), .convErr(convErr));
endmodule

// File: tb/qenc_emulator_tb.sv
module qenc_emulator_tb;
  localparam int W = 15;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sampleValid = 1'b0, dirInvert = 1'b0, autoClear = 1'b0, clearErr = 1'b0;
  logic [W-1:0] angleIn = '0;
  logic quadA, quadB, index, convErr;

  int checks = 0, errors = 0;
  int eRef = 0, ePhase = 0;
  bit eValid = 0, eErr = 0;

  always #4 clk = ~clk;

  qenc_emulator #(.ANGLE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .angleIn(angleIn),
    .dirInvert(dirInvert), .autoClear(autoClear), .clearErr(clearErr),
    .quadA(quadA), .quadB(quadB), .index(index), .convErr(convErr));

  function automatic logic [1:0] grayOf(int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(string tag);
    logic [3:0] act, exp;
    act = {quadA, quadB, index, convErr};
    exp = {grayOf(ePhase), eValid && eRef == 0, eErr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {A,B,index,err} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Model from the requirements: one strobe plus optional clear command
  task automatic sample(int a, bit clr, string tag);
    int d;
    bit jump = 0;
    @(negedge clk);
    angleIn = W'(a); sampleValid = 1'b1; clearErr = clr;
    @(negedge clk);
    sampleValid = 1'b0; clearErr = 1'b0;
    if (!eValid) begin eValid = 1; eRef = a; end
    else begin
      d = (a - eRef) & MASK;
      if (d == 1 || d == MASK) begin
        ePhase = ePhase + (((d == 1) ^ dirInvert) ? 1 : 3);
        eRef = a;
      end else if (d != 0) begin jump = 1; eRef = a; end
    end
    if (jump) eErr = 1;
    else if (clr || (autoClear && a == 0)) eErr = 0;
    check(tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    sample(100, 0, "R2 first sample");
    sample(100, 0, "R4 same sample");
    // full revolution upward, through the wrap (R3, R6, R11)
    for (int i = 1; i <= 32768; i++) sample((100 + i) & MASK, 0, "R3 R6 R11 up sweep");
    for (int i = 1; i <= 200; i++) sample((100 - i) & MASK, 0, "R3 R6 down sweep");
    sample(eRef, 0, "R4 repeat");
    dirInvert = 1'b1;
    for (int i = 1; i <= 50; i++) sample((eRef + 1) & MASK, 0, "R5 inverted up");
    for (int i = 1; i <= 9; i++) sample((eRef - 1) & MASK, 0, "R5 inverted down");
    dirInvert = 1'b0;

    // R12: strobe low, angle changes ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); angleIn = W'(i * 777);
      @(negedge clk); check("R12 idle input ignored");
    end
    sample((eRef + 1) & MASK, 0, "R12 reference kept");

    // R7, R8, R9
    sample((eRef + 5) & MASK, 0, "R7 jump sets error");
    sample((eRef + 1) & MASK, 0, "R8 error sticky over step");
    sample((eRef - 2) & MASK, 0, "R7 second jump");
    sample(eRef, 1, "R9 clear command");
    sample((eRef + 3) & MASK, 1, "R9 jump beats clear");
    sample((eRef + 1) & MASK, 1, "R9 clear with step");

    // R10 autoClear off: passing zero keeps error
    sample(32765, 0, "R7 jump near wrap");
    sample(32766, 0, "R8 sticky");
    sample(32767, 0, "R8 sticky");
    sample(0, 0, "R10 no autoclear at zero");
    sample(1, 0, "R10 still set");
    // autoClear on
    autoClear = 1'b1;
    sample(32765, 0, "R7 jump near wrap");
    sample(32766, 0, "R10 not yet zero");
    sample(32767, 0, "R10 not yet zero");
    sample(0, 0, "R10 autoclear at zero");
    sample(1, 0, "R11 index drops");
    sample(0, 0, "R11 index back");
    sample(300, 0, "R7 jump off zero");
    sample(0, 0, "R10 jump onto zero keeps error");
    sample(1, 0, "R8 sticky");
    sample(0, 0, "R10 step onto zero clears");
    autoClear = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule